// File: doc/BRIEF.md
# Register-Stepped I2C Bus Master

This block is an I2C master that software moves forward one bus event at a time. Five byte-wide registers sit on a simple single-cycle write port with a combinational read port. They are control, status, data, clock divider and soft reset. Each event is one of START, repeated START, address or data byte out, data byte in, or STOP. When an event completes, the controller raises a flag in the control register and holds SCL low. Software then reads a status code describing what happened and clears the flag to launch the next event. No event runs on its own.

SCL and SDA are open-drain: the block only ever pulls a line low through `scl_oe` / `sda_oe` and reads the resolved SDA level back. Every register access is a single-cycle write or a same-cycle read, so the register port has no back-pressure.

Register map (`reg_addr`):
- 0 is control. Bit 0 is bus enable, bit 1 is start request, bit 2 is stop request, bit 3 is the event flag and bit 4 is ACK enable.
- 1 is status (read-only).
- 2 is data.
- 3 is the clock divider. Bits [2:0] hold N and bits [6:3] hold M.
- 4 is soft reset.

Top module: `i2c_step_master`

## Requirements
- R1: After reset, status reads 8'hF8, control reads 8'h00, soft reset reads 0, and both SCL and SDA are released.
- R2: With bus enable set and the flag clear, writing 1 to control bit 1 produces a START (SDA falls while SCL is high), or a repeated START if the bus is already owned. Bit 1 then clears, the flag (bit 3) sets, and status reads 8'h08 for a START or 8'h10 for a repeated START.
- R3: While control bit 0 is 0, no event begins, the bus pins do not move and status stays 8'hF8; a pending start request is acted on once bit 0 is set.
- R4: While the flag is set, SCL and SDA hold their levels. Writing control with bit 3 = 0 clears the flag and launches the next event. Writing bit 3 = 1 leaves the flag unchanged.
- R5: The first byte after a START or repeated START is the address, sent MSB first from the data register; its bit 0 selects read (1) or write (0). The slave's ninth-clock answer gives status 8'h18 (ACK) or 8'h20 (NAK) for write, and 8'h40 or 8'h48 for read.
- R6: In write mode each data byte is sent MSB first and gives status 8'h28 on ACK or 8'h30 on NAK.
- R7: In read mode each step shifts one byte in, MSB first, into the data register. The master drives ACK if control bit 4 is set (status 8'h50) and NAK otherwise (status 8'h58).
- R8: Writing 1 to control bit 2 with the flag clear produces a STOP (SDA rises while SCL is high). Both lines are then released, bit 2 clears, no flag is raised, and status returns to 8'hF8.
- R9: Status reads 8'hF8 whenever the bus is not owned.
- R10: The SCL period is 4 x 2^N x (M+1) input clock cycles.
- R11: Writing 1 to register 4 reads back 1 for SRST_CYCLES cycles, then 0. During that time both lines are released and the start, stop, flag and ACK bits and the bus state are cleared. Bus enable and the divider are kept.
- R12: SDA changes only while SCL is low, except during START and STOP generation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 3 | Register select for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr, same cycle |
| sda_in | input | 1 | Resolved SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
Several properties are checked on every cycle:
- the pins stay frozen while the flag is up or the bus is disabled;
- SDA stays still under a high SCL outside START and STOP;
- the idle code shows whenever the bus is unowned;
- a start request only retires together with a raised flag;
- both lines are released throughout a soft reset.

The bench's transaction scenarios are needed for the rest. These cover the status code chosen for each kind of step, MSB-first byte order in both directions, the ACK/NAK the master drives on reads, and the measured SCL period for two divider settings. They also cover the soft reset read-back timing and what the reset preserves.

// File: rtl/i2c_step_pkg.sv
package i2c_step_pkg;
  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_STAT = 3'd1;
  localparam logic [2:0] A_DATA = 3'd2;
  localparam logic [2:0] A_CLK  = 3'd3;
  localparam logic [2:0] A_SRST = 3'd4;

  localparam int CB_EN  = 0;
  localparam int CB_STA = 1;
  localparam int CB_STO = 2;
  localparam int CB_FLG = 3;
  localparam int CB_ACK = 4;

  localparam logic [7:0] ST_IDLE    = 8'hF8;
  localparam logic [7:0] ST_START   = 8'h08;
  localparam logic [7:0] ST_RSTART  = 8'h10;
  localparam logic [7:0] ST_AW_ACK  = 8'h18;
  localparam logic [7:0] ST_AW_NAK  = 8'h20;
  localparam logic [7:0] ST_TX_ACK  = 8'h28;
  localparam logic [7:0] ST_TX_NAK  = 8'h30;
  localparam logic [7:0] ST_AR_ACK  = 8'h40;
  localparam logic [7:0] ST_AR_NAK  = 8'h48;
  localparam logic [7:0] ST_RX_ACK  = 8'h50;
  localparam logic [7:0] ST_RX_NAK  = 8'h58;

  typedef enum logic [1:0] {BC_START, BC_STOP, BC_WBIT, BC_RBIT} bitcmd_e;
  typedef enum logic [1:0] {S_IDLE, S_START, S_STOP, S_BYTE} seq_e;
endpackage

// File: rtl/i2c_step_clkdiv.sv
module i2c_step_clkdiv #(
  parameter int NW = 3,
  parameter int MW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [NW-1:0] n_sel,
  input  logic [MW-1:0] m_sel,
  output logic          tick
);
  localparam int PW = (1 << NW) - 1;
  localparam logic [PW:0] ONE = 1;

  logic [PW-1:0] pre_cnt;
  logic [MW-1:0] main_cnt;
  logic [PW:0]   pre_lim;
  logic          pre_tick;

  assign pre_lim  = (ONE << n_sel) - ONE;
  assign pre_tick = run && (pre_cnt == pre_lim[PW-1:0]);
  assign tick     = pre_tick && (main_cnt == m_sel);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      pre_cnt  <= '0;
      main_cnt <= '0;
    end else if (pre_tick) begin
      pre_cnt  <= '0;
      main_cnt <= (main_cnt == m_sel) ? '0 : main_cnt + MW'(1);
    end else begin
      pre_cnt  <= pre_cnt + PW'(1);
    end
  end
endmodule

// File: rtl/i2c_step_bitengine.sv
module i2c_step_bitengine
  import i2c_step_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    clr,
  input  logic    tick,
  input  logic    cmd_valid,
  input  bitcmd_e cmd,
  input  logic    wbit,
  input  logic    sda_in,
  output logic    busy,
  output logic    done,
  output logic    rbit,
  output logic    scl_oe,
  output logic    sda_oe
);
  bitcmd_e    cmd_q;
  logic [1:0] ph_q;
  logic       wbit_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      ph_q   <= 2'd0;
      cmd_q  <= BC_START;
      wbit_q <= 1'b1;
      rbit   <= 1'b1;
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (cmd_valid) begin
          busy   <= 1'b1;
          ph_q   <= 2'd0;
          cmd_q  <= cmd;
          wbit_q <= wbit;
        end
      end else if (tick) begin
        case (cmd_q)
          BC_START: case (ph_q)
            2'd0: sda_oe <= 1'b0;
            2'd1: scl_oe <= 1'b0;
            2'd2: sda_oe <= 1'b1;
            default: scl_oe <= 1'b1;
          endcase
          BC_STOP: case (ph_q)
            2'd0: sda_oe <= 1'b1;
            2'd1: scl_oe <= 1'b0;
            2'd2: sda_oe <= 1'b0;
            default: ;
          endcase
          BC_WBIT: case (ph_q)
            2'd0: sda_oe <= !wbit_q;
            2'd1: scl_oe <= 1'b0;
            2'd2: ;
            default: scl_oe <= 1'b1;
          endcase
          default: case (ph_q)
            2'd0: sda_oe <= 1'b0;
            2'd1: scl_oe <= 1'b0;
            2'd2: rbit   <= sda_in;
            default: scl_oe <= 1'b1;
          endcase
        endcase
        if (ph_q == 2'd3) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          ph_q <= ph_q + 2'd1;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_step_master.sv
module i2c_step_master
  import i2c_step_pkg::*;
#(
  parameter int NW          = 3,
  parameter int MW          = 4,
  parameter int SRST_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe
);
  localparam int CW = NW + MW;
  localparam int SW = $clog2(SRST_CYCLES + 1);
  localparam logic [CW-1:0] CLK_INIT = CW'((1 << NW) | 1);

  logic en_q, sta_q, sto_q, flg_q, ack_q, go_q;
  logic owned_q, rd_mode_q, addr_next_q, byte_addr_q, pend_q;
  logic [7:0] data_q, sh_q, stat_q;
  logic [CW-1:0] clk_q;
  logic [SW-1:0] srst_cnt;
  logic [3:0] bitcnt;
  logic sda_s1, sda_s2;
  seq_e state_q;

  logic srst_busy, tick, eng_busy, eng_done, eng_rbit, cmd_valid, wbit, rd_byte, cond_busy;
  bitcmd_e cmd;

  assign srst_busy = (srst_cnt != '0);
  assign rd_byte   = rd_mode_q && !byte_addr_q;
  assign cond_busy = (state_q == S_START) || (state_q == S_STOP);
  assign cmd_valid = (state_q != S_IDLE) && !pend_q && !eng_busy && !srst_busy;

  always_comb begin
    cmd  = BC_START;
    wbit = 1'b1;
    case (state_q)
      S_STOP: cmd = BC_STOP;
      S_BYTE: begin
        if (bitcnt != 4'd8) begin
          cmd  = rd_byte ? BC_RBIT : BC_WBIT;
          wbit = sh_q[7];
        end else begin
          cmd  = rd_byte ? BC_WBIT : BC_RBIT;
          wbit = !ack_q;
        end
      end
      default: cmd = BC_START;
    endcase
  end

  i2c_step_clkdiv #(.NW(NW), .MW(MW)) u_div (
    .clk(clk), .rst_n(rst_n), .run(en_q && !srst_busy),
    .n_sel(clk_q[NW-1:0]), .m_sel(clk_q[CW-1:NW]), .tick(tick)
  );

  i2c_step_bitengine u_eng (
    .clk(clk), .rst_n(rst_n), .clr(srst_busy), .tick(tick),
    .cmd_valid(cmd_valid), .cmd(cmd), .wbit(wbit), .sda_in(sda_s2),
    .busy(eng_busy), .done(eng_done), .rbit(eng_rbit),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sda_s1 <= 1'b1;
      sda_s2 <= 1'b1;
    end else begin
      sda_s1 <= sda_in;
      sda_s2 <= sda_s1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0; sta_q <= 1'b0; sto_q <= 1'b0; flg_q <= 1'b0; ack_q <= 1'b0;
      go_q <= 1'b0; owned_q <= 1'b0; rd_mode_q <= 1'b0; addr_next_q <= 1'b0;
      byte_addr_q <= 1'b0; pend_q <= 1'b0; data_q <= '0; sh_q <= '0;
      stat_q <= ST_IDLE; clk_q <= CLK_INIT; srst_cnt <= '0; bitcnt <= '0;
      state_q <= S_IDLE;
    end else begin
      if (reg_we && reg_addr == A_SRST && reg_wdata[0]) srst_cnt <= SW'(SRST_CYCLES);
      else if (srst_busy) srst_cnt <= srst_cnt - SW'(1);

      if (srst_busy) begin
        sta_q <= 1'b0; sto_q <= 1'b0; flg_q <= 1'b0; ack_q <= 1'b0; go_q <= 1'b0;
        owned_q <= 1'b0; rd_mode_q <= 1'b0; addr_next_q <= 1'b0; pend_q <= 1'b0;
        stat_q <= ST_IDLE; state_q <= S_IDLE; bitcnt <= '0;
      end else begin
        if (reg_we) begin
          case (reg_addr)
            A_CTRL: begin
              en_q  <= reg_wdata[CB_EN];
              ack_q <= reg_wdata[CB_ACK];
              if (reg_wdata[CB_STA]) sta_q <= 1'b1;
              if (reg_wdata[CB_STO]) sto_q <= 1'b1;
              if (flg_q && !reg_wdata[CB_FLG]) begin
                flg_q <= 1'b0;
                go_q  <= 1'b1;
              end
            end
            A_DATA:  data_q <= reg_wdata;
            A_CLK:   clk_q  <= reg_wdata[CW-1:0];
            default: ;
          endcase
        end

        if (cmd_valid) pend_q <= 1'b1;
        else if (eng_done) pend_q <= 1'b0;

        case (state_q)
          S_IDLE: if (en_q && !flg_q) begin
            if (sta_q) begin
              state_q <= S_START; go_q <= 1'b0;
            end else if (sto_q) begin
              state_q <= S_STOP; go_q <= 1'b0;
            end else if (go_q && owned_q) begin
              state_q     <= S_BYTE;
              go_q        <= 1'b0;
              bitcnt      <= '0;
              sh_q        <= data_q;
              byte_addr_q <= addr_next_q;
              addr_next_q <= 1'b0;
              if (addr_next_q) rd_mode_q <= data_q[0];
            end
          end
          S_START: if (eng_done) begin
            state_q     <= S_IDLE;
            sta_q       <= 1'b0;
            flg_q       <= 1'b1;
            stat_q      <= owned_q ? ST_RSTART : ST_START;
            owned_q     <= 1'b1;
            addr_next_q <= 1'b1;
          end
          S_STOP: if (eng_done) begin
            state_q   <= S_IDLE;
            sto_q     <= 1'b0;
            owned_q   <= 1'b0;
            rd_mode_q <= 1'b0;
            stat_q    <= ST_IDLE;
          end
          default: if (eng_done) begin
            if (bitcnt != 4'd8) begin
              bitcnt <= bitcnt + 4'd1;
              sh_q   <= {sh_q[6:0], eng_rbit};
            end else begin
              state_q <= S_IDLE;
              flg_q   <= 1'b1;
              if (rd_byte) begin
                data_q <= sh_q;
                stat_q <= ack_q ? ST_RX_ACK : ST_RX_NAK;
              end else if (byte_addr_q) begin
                if (rd_mode_q) stat_q <= eng_rbit ? ST_AR_NAK : ST_AR_ACK;
                else           stat_q <= eng_rbit ? ST_AW_NAK : ST_AW_ACK;
              end else begin
                stat_q <= eng_rbit ? ST_TX_NAK : ST_TX_ACK;
              end
            end
          end
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {3'b000, ack_q, flg_q, sto_q, sta_q, en_q};
      A_STAT:  reg_rdata = stat_q;
      A_DATA:  reg_rdata = data_q;
      A_CLK:   reg_rdata = 8'(clk_q);
      A_SRST:  reg_rdata = {7'd0, srst_busy};
      default: reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/i2c_step_master_chk.sv
module i2c_step_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       flag,
  input logic       start_req,
  input logic       owned,
  input logic [7:0] status,
  input logic       srst_busy,
  input logic       bus_en,
  input logic       cond_busy
);
  p_start_retire_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(start_req) && !srst_busy) |-> flag);

  p_disabled_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_en && $past(!bus_en) && !srst_busy && !$past(srst_busy))
      |-> ($stable(scl_oe) && $stable(sda_oe)));

  p_flag_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && $past(flag) && !srst_busy) |-> ($stable(scl_oe) && $stable(sda_oe)));

  p_idle_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !owned |-> (status == 8'hF8));

  p_srst_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_busy && $past(srst_busy)) |-> (!scl_oe && !sda_oe));

  p_sda_still_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && $past(!scl_oe) && !cond_busy && !srst_busy) |-> $stable(sda_oe));
endmodule

bind i2c_step_master i2c_step_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .flag(flg_q), .start_req(sta_q), .owned(owned_q), .status(stat_q),
  .srst_busy(srst_busy), .bus_en(en_q), .cond_busy(cond_busy)
);

// File: tb/i2c_step_master_tb_top.sv
`timescale 1ns/1ps
module i2c_step_master_tb_top;
  import i2c_step_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0, reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       scl_oe, sda_oe;
  logic       slv_low = 1'b0;
  wire scl_line = !scl_oe;
  wire sda_line = !(sda_oe || slv_low);

  int errs = 0, checks = 0;
  bit model_free = 1'b1;
  longint rise_q[$];
  logic [7:0] wr_log[$];

  i2c_step_master dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sda_in(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  // ---- behavioural slave at 7-bit address 0x50 ----
  int s_ph = 0;   // 0 idle, 1 address, 2 write data, 3 read data
  int s_cnt = 0;
  int rd_idx = 0;
  logic [7:0] s_sh = 8'h00;
  logic [7:0] rbyte;
  assign rbyte = 8'h3C + 8'(8'h11 * rd_idx);

  always @(negedge sda_line) if (scl_line) begin s_ph = 1; s_cnt = 0; slv_low = 1'b0; end
  always @(posedge sda_line) if (scl_line) begin s_ph = 0; slv_low = 1'b0; end
  always @(posedge scl_line) begin
    rise_q.push_back($time);
    if (s_ph != 0) begin
      if (s_cnt < 8) begin s_sh = {s_sh[6:0], sda_line}; s_cnt++; end
      else begin s_cnt = 0; if (s_ph == 3 && sda_line) s_ph = 0; end
    end
  end
  always @(negedge scl_line) if (s_ph != 0) begin
    if (s_cnt == 8) begin
      if (s_ph == 1) begin
        if (s_sh[7:1] == 7'h50) begin slv_low = 1'b1; s_ph = s_sh[0] ? 3 : 2; end
        else begin slv_low = 1'b0; s_ph = 0; end
      end else if (s_ph == 2) begin
        wr_log.push_back(s_sh); slv_low = (s_sh != 8'hFF);
      end else begin
        slv_low = 1'b0; rd_idx++;
      end
    end else begin
      slv_low = (s_ph == 3) ? !rbyte[7 - s_cnt] : 1'b0;
    end
  end

  // ---- checks ----
  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && model_free)
    chk("R8 free bus lines high", {scl_line, sda_line}, 2'b11);

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask
  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask
  task automatic wait_flag(input string tag);
    logic [7:0] v = 8'h00;
    for (int n = 0; n < 5000 && !v[CB_FLG]; n++) rd(A_CTRL, v);
    if (!v[CB_FLG]) chk({tag, " flag"}, 0, 1);
  endtask
  task automatic step(input logic [7:0] cv, input logic [7:0] es, input string tag);
    logic [7:0] v;
    wr(A_CTRL, cv); wait_flag(tag); rd(A_STAT, v); chk(tag, v, es);
  endtask
  task automatic send(input logic [7:0] b, input logic [7:0] es, input string tag);
    wr(A_DATA, b); step(8'h01, es, tag);
  endtask
  task automatic do_stop();
    logic [7:0] s = 8'h00, c = 8'hFF;
    wr(A_CTRL, 8'h05);
    for (int n = 0; n < 5000 && !(s == ST_IDLE && !c[CB_STO]); n++) begin
      rd(A_STAT, s); rd(A_CTRL, c);
    end
    chk("R8 stop status", s, ST_IDLE);
    chk("R8 stop ctrl", c, 8'h01);
    chk("R8 lines released", {scl_line, sda_line}, 2'b11);
    model_free = 1'b1;
  endtask
  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] v, l0, l1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(A_STAT, v); chk("R1 status", v, ST_IDLE);
    rd(A_CTRL, v); chk("R1 ctrl", v, 8'h00);
    rd(A_SRST, v); chk("R1 srst", v, 8'h00);
    chk("R1 pins", {scl_oe, sda_oe}, 2'b00);

    // R3 start request with bus disabled does nothing
    wr(A_CTRL, 8'h02);
    repeat (100) @(negedge clk);
    rd(A_CTRL, v); chk("R3 start pending", v, 8'h02);
    rd(A_STAT, v); chk("R3 status idle", v, ST_IDLE);
    model_free = 1'b0;
    step(8'h03, ST_START, "R2 start");
    rd(A_CTRL, v); chk("R2 start bit cleared, flag set", v, 8'h09);

    // R5/R6 write transfer, R10 default period
    send(8'hA0, ST_AW_ACK, "R5 addr write ack");
    l0 = {6'd0, scl_line, sda_line};
    repeat (60) @(negedge clk);
    l1 = {6'd0, scl_line, sda_line};
    chk("R4 bus held under flag", l1, l0);
    wr(A_CTRL, 8'h09);
    repeat (60) @(negedge clk);
    rd(A_CTRL, v); chk("R4 flag=1 write keeps flag", v, 8'h09);
    rise_q.delete();
    send(8'h07, ST_TX_ACK, "R6 data ack");
    chk("R10 period default", rise_q[1] - rise_q[0], 160);
    send(8'h5A, ST_TX_ACK, "R6 data ack 2");
    send(8'hFF, ST_TX_NAK, "R6 data nak");
    do_stop();
    chk("R6 slave byte count", wr_log.size(), 3);
    chk("R6 msb first 0", wr_log[0], 8'h07);
    chk("R6 msb first 1", wr_log[1], 8'h5A);
    chk("R6 msb first 2", wr_log[2], 8'hFF);

    // R7 read transfer with repeated start
    model_free = 1'b0;
    step(8'h03, ST_START, "R2 start 2");
    send(8'hA0, ST_AW_ACK, "R5 addr write ack 2");
    send(8'h00, ST_TX_ACK, "R6 register index");
    step(8'h03, ST_RSTART, "R2 repeated start");
    send(8'hA1, ST_AR_ACK, "R5 addr read ack");
    wr(A_CTRL, 8'h19);
    step(8'h11, ST_RX_ACK, "R7 rx ack 1");
    rd(A_DATA, v); chk("R7 rx byte 1", v, 8'h3C);
    step(8'h11, ST_RX_ACK, "R7 rx ack 2");
    rd(A_DATA, v); chk("R7 rx byte 2", v, 8'h4D);
    step(8'h01, ST_RX_NAK, "R7 rx nak last");
    rd(A_DATA, v); chk("R7 rx byte 3", v, 8'h5E);
    do_stop();

    // R5 address NAK cases
    model_free = 1'b0;
    step(8'h03, ST_START, "R2 start 3");
    send(8'h66, ST_AW_NAK, "R5 addr write nak");
    do_stop();
    model_free = 1'b0;
    step(8'h03, ST_START, "R2 start 4");
    send(8'h67, ST_AR_NAK, "R5 addr read nak");
    do_stop();

    // R10 second divider setting: N=2, M=2 -> 48 cycles
    wr(A_CLK, 8'h12);
    model_free = 1'b0;
    step(8'h03, ST_START, "R2 start 5");
    rise_q.delete();
    send(8'hA0, ST_AW_ACK, "R5 addr ack slow");
    chk("R10 period N2 M2", rise_q[1] - rise_q[0], 480);

    // R11 soft reset while owning the bus
    wr(A_SRST, 8'h01);
    rd(A_SRST, v); chk("R11 srst busy", v, 8'h01);
    repeat (12) @(negedge clk);
    rd(A_SRST, v); chk("R11 srst done", v, 8'h00);
    rd(A_STAT, v); chk("R11 status idle", v, ST_IDLE);
    rd(A_CTRL, v); chk("R11 ctrl keeps enable only", v, 8'h01);
    rd(A_CLK, v);  chk("R11 divider kept", v, 8'h12);
    chk("R11 lines released", {scl_line, sda_line}, 2'b11);
    model_free = 1'b1;
    repeat (20) @(negedge clk);
    finish_run();
  end
endmodule